// File: doc/BRIEF.md
# Decoder Bit Error Rate Estimator

This block runs beside a rate-1/2 convolutional decoder and estimates how many channel bit errors each output block held. It takes the decoded bit stream, with a valid strobe and a start-of-block marker, and passes every decoded bit through a local convolutional encoder. The encoder uses the same two generator polynomials as the transmitter. Each of the two coded bits it rebuilds is compared with the hard decision that was actually received for that position. Every disagreement adds one to a per-block error count.

The received hard decisions and their erasure flags enter the block a fixed number of cycles ahead of the decoded bit they belong to. That number is the decoder latency. An internal delay line of parameter depth lines them up. For a soft symbol, the hard decision is its most significant bit, with 1 meaning '1' and 0 meaning '0'. The front end supplies that bit. Positions flagged as erased or punctured are left out of the comparison. The count restarts at every block start and follows each error as it is found, so the place of every error can be seen on the output. A clear input zeroes the count at any time. The estimate is only accurate while the decoder output is itself error-free. When it is not, the count runs above the true number of channel errors.

Top module: `ber_estimator`

## Requirements
- R1: After reset, `numerr` is 0 and the encoder history is all zero.
- R2: A decoded bit forms an L-bit window: position 0 holds the current bit and position k holds the bit k accepted bits earlier. Coded bit A is the XOR of the window bits selected by POLY_A, and coded bit B is the XOR of the bits selected by POLY_B. `rx_hard[0]`/`rx_eras[0]` belong to coded bit A, and `rx_hard[1]`/`rx_eras[1]` belong to coded bit B.
- R3: Each coded bit whose received hard decision differs from the re-encoded bit adds one to the count. A decoded bit accepted at clock edge E changes `numerr` at the next edge E+1, so the count moves live at each error.
- R4: A decoded bit accepted with `dec_sop` high is encoded with an all-zero history. The count then restarts at that bit's own mismatches (0, 1 or 2), visible after the next edge.
- R5: A coded position whose erasure flag is set never adds to the count, whatever its hard decision.
- R6: The hard decisions and erasure flags for a decoded bit are presented exactly DELAY cycles before that decoded bit.
- R7: `clr` high at an edge makes `numerr` 0 after that edge. Any increment or restart that would apply at the same edge is discarded.
- R8: The count saturates at 2^CNT_W-1 and holds there until a restart or a clear.
- R9: Cycles with `dec_valid` low change neither the count nor the encoder history. This holds whatever `dec_bit`, `dec_sop`, `rx_hard` and `rx_eras` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Zero the error count |
| dec_valid | input | 1 | Decoded bit valid |
| dec_bit | input | 1 | Decoded bit |
| dec_sop | input | 1 | First decoded bit of a block |
| rx_hard | input | 2 | Received hard decisions, bit 0 for coded bit A, bit 1 for coded bit B |
| rx_eras | input | 2 | Erasure flags, same lane order as `rx_hard` |
| numerr | output | CNT_W | Error count of the current block |

## Verification
The first pattern is a clean stream that is exactly the encoding of the decoded bits, with regular block starts. A zero count there separates correct tap order, lane order and delay alignment from any off-by-one in the encoder or the delay line. Sparse random flips, and then flips mixed with random erasures, give counts that show whether each lane is compared and each erasure masks the right lane. Streams with random idle cycles carrying junk, clears that land on block starts and pending increments, and a long run in which every bit is flipped then check idle handling, clear priority and saturation.

// File: rtl/ber_est_pkg.sv
package ber_est_pkg;

  localparam int unsigned NCODE = 2;
  localparam int unsigned MM_W  = 2;

  // Number of set bits in a two-lane mismatch vector.
  function automatic logic [MM_W-1:0] lane_count(input logic [NCODE-1:0] v);
    lane_count = {1'b0, v[0]} + {1'b0, v[1]};
  endfunction

endpackage

// File: rtl/ber_align_dly.sv
module ber_align_dly #(
  parameter int unsigned W     = 4,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_pipe
      logic [W-1:0] stage_q [DEPTH];
      logic [W-1:0] stage_d [DEPTH];

      always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
          stage_d[i] = stage_q[i-1];
        end
      end

      for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stage_q[g] <= '0;
          end else begin
            stage_q[g] <= stage_d[g];
          end
        end
      end

      assign dout = stage_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/ber_reenc.sv
module ber_reenc
  import ber_est_pkg::*;
#(
  parameter int unsigned    L      = 7,
  parameter logic [L-1:0]   POLY_A = 7'd121,
  parameter logic [L-1:0]   POLY_B = 7'd91
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic             in_sop,
  input  logic [NCODE-1:0] rx_hard,
  input  logic [NCODE-1:0] rx_eras,
  output logic             upd_q,
  output logic             sop_q,
  output logic [MM_W-1:0]  mm_q
);

  localparam int unsigned HW = L - 1;

  logic [HW-1:0]    hist_q, hist_d, hist_base;
  logic [L-1:0]     win;
  logic [NCODE-1:0] code, miss;
  logic [MM_W-1:0]  mm_d;

  always_comb begin
    hist_base = in_sop ? '0 : hist_q;
    win       = {hist_base, in_bit};
    code[0]   = ^(win & POLY_A);
    code[1]   = ^(win & POLY_B);
    miss      = (code ^ rx_hard) & ~rx_eras;
    mm_d      = lane_count(miss);
    hist_d    = win[HW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (in_valid) begin
      hist_q <= hist_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
    end else begin
      upd_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sop_q <= 1'b0;
      mm_q  <= '0;
    end else if (in_valid) begin
      sop_q <= in_sop;
      mm_q  <= mm_d;
    end
  end

endmodule

// File: rtl/ber_err_cnt.sv
module ber_err_cnt
  import ber_est_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             restart,
  input  logic [MM_W-1:0]  inc,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic [CNT_W:0]   sum;
  logic             cnt_en;

  always_comb begin
    base   = restart ? '0 : cnt_q;
    sum    = {1'b0, base} + {{(CNT_W + 1 - MM_W){1'b0}}, inc};
    cnt_en = clr | upd;
    if (clr) begin
      cnt_d = '0;
    end else if (sum[CNT_W]) begin
      cnt_d = CNT_MAX;
    end else begin
      cnt_d = sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/ber_estimator.sv
module ber_estimator
  import ber_est_pkg::*;
#(
  parameter int unsigned  L      = 7,
  parameter logic [L-1:0] POLY_A = 7'd121,
  parameter logic [L-1:0] POLY_B = 7'd91,
  parameter int unsigned  DELAY  = 4,
  parameter int unsigned  CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             dec_valid,
  input  logic             dec_bit,
  input  logic             dec_sop,
  input  logic [1:0]       rx_hard,
  input  logic [1:0]       rx_eras,
  output logic [CNT_W-1:0] numerr
);

  localparam int unsigned LANE_W = 2 * NCODE;

  logic [LANE_W-1:0] lane_in, lane_dly;
  logic              upd, restart;
  logic [MM_W-1:0]   mm;

  assign lane_in = {rx_eras, rx_hard};

  ber_align_dly #(
    .W     (LANE_W),
    .DEPTH (DELAY)
  ) i_align (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (lane_in),
    .dout  (lane_dly)
  );

  ber_reenc #(
    .L      (L),
    .POLY_A (POLY_A),
    .POLY_B (POLY_B)
  ) i_reenc (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (dec_valid),
    .in_bit   (dec_bit),
    .in_sop   (dec_sop),
    .rx_hard  (lane_dly[NCODE-1:0]),
    .rx_eras  (lane_dly[LANE_W-1:NCODE]),
    .upd_q    (upd),
    .sop_q    (restart),
    .mm_q     (mm)
  );

  ber_err_cnt #(
    .CNT_W (CNT_W)
  ) i_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .upd     (upd),
    .restart (restart),
    .inc     (mm),
    .cnt     (numerr)
  );

endmodule

// File: rtl/ber_estimator_chk.sv
module ber_estimator_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             dec_valid,
  input logic             dec_sop,
  input logic [CNT_W-1:0] numerr
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic act_d1, sop_d1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_d1 <= 1'b0;
      sop_d1 <= 1'b0;
    end else begin
      act_d1 <= dec_valid;
      sop_d1 <= dec_valid & dec_sop;
    end
  end

  // R3
  incr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !sop_d1) |=> ((numerr >= $past(numerr)) &&
      ({1'b0, numerr} <= {1'b0, $past(numerr)} + (CNT_W + 1)'(2))));

  // R4
  sop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sop_d1 && !clr) |=> (numerr <= CNT_W'(2)));

  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (numerr == '0));

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (numerr == CNT_MAX && !clr && !sop_d1) |=> (numerr == CNT_MAX));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !act_d1) |=> $stable(numerr));

endmodule

bind ber_estimator ber_estimator_chk #(
  .CNT_W (CNT_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .dec_valid (dec_valid),
  .dec_sop   (dec_sop),
  .numerr    (numerr)
);

// File: tb/test_ber_estimator.sv
`timescale 1ns/1ps
module test_ber_estimator;

  localparam int unsigned  L   = 7;
  localparam logic [L-1:0] PA  = 7'd121;
  localparam logic [L-1:0] PB  = 7'd91;
  localparam int           DLY = 4;
  localparam int unsigned  CW  = 8;
  localparam int           N   = 1200;
  localparam int           MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr, dec_valid, dec_bit, dec_sop;
  logic [1:0]    rx_hard, rx_eras;
  logic [CW-1:0] numerr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic       e_dv [N];
  logic       e_bit[N];
  logic       e_sop[N];
  logic       e_clr[N];
  logic [1:0] e_hard[N];
  logic [1:0] e_eras[N];
  int         e_mm [N];

  always #2 clk = ~clk;

  ber_estimator #(
    .L (L), .POLY_A (PA), .POLY_B (PB), .DELAY (DLY), .CNT_W (CW)
  ) i_ber_estimator (
    .clk (clk), .rst_n (rst_n), .clr (clr), .dec_valid (dec_valid),
    .dec_bit (dec_bit), .dec_sop (dec_sop), .rx_hard (rx_hard),
    .rx_eras (rx_eras), .numerr (numerr)
  );

  function automatic string tag_of(input int i);
    case (i / 150)
      0:       tag_of = "R2 R4 R6";
      1:       tag_of = "R3";
      2:       tag_of = "R5";
      3:       tag_of = "R9";
      4:       tag_of = "R7";
      5, 6:    tag_of = "R8";
      default: tag_of = "R7 R4 R5";
    endcase
  endfunction

  function automatic int sat(input int v);
    sat = (v > MAXC) ? MAXC : v;
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s numerr=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: run hung, numerr=%0d expected=completion", numerr);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hist, exp_cnt;
    // Stimulus table with a bench-side reference encoder
    hist = 0;
    for (int i = 0; i < N; i++) begin
      int seg, w;
      logic [1:0] flip, code;
      seg = i / 150;
      e_dv[i] = 1'b1; e_sop[i] = 1'b0; e_clr[i] = 1'b0;
      e_bit[i] = 1'($urandom % 2); flip = 2'b00; e_eras[i] = 2'b00;
      case (seg)
        0: e_sop[i] = (i % 50 == 0);
        1: begin
          e_sop[i] = (i % 40 == 0);
          flip = {($urandom % 4) == 0, ($urandom % 4) == 0};
        end
        2: begin
          e_sop[i] = (i % 40 == 0);
          flip = 2'($urandom); e_eras[i] = 2'($urandom);
        end
        3: begin
          e_dv[i] = 1'($urandom % 2);
          e_sop[i] = (($urandom % 8) == 0);
          flip = {($urandom % 4) == 0, ($urandom % 4) == 0};
        end
        4: begin
          e_sop[i] = (i % 30 == 0);
          e_clr[i] = (($urandom % 8) == 0);
          flip = {($urandom % 4) == 0, ($urandom % 4) == 0};
        end
        5, 6: begin
          e_sop[i] = (i == 750);
          flip = 2'b11;
        end
        default: begin
          e_sop[i] = (i % 10 == 0);
          e_clr[i] = (($urandom % 5) == 0);
          flip = 2'($urandom); e_eras[i] = 2'($urandom);
        end
      endcase
      if (e_dv[i]) begin
        if (e_sop[i]) hist = 0;
        w = (hist << 1) | int'(e_bit[i]);
        code[0] = ^(w[L-1:0] & PA);
        code[1] = ^(w[L-1:0] & PB);
        e_hard[i] = code ^ flip;
        e_mm[i] = int'(flip[0] & ~e_eras[i][0]) + int'(flip[1] & ~e_eras[i][1]);
        hist = w & ((1 << (L - 1)) - 1);
      end else begin
        e_hard[i] = 2'($urandom);
        e_eras[i] = 2'($urandom);
        e_mm[i] = 0;
      end
    end

    rst_n = 1'b0; clr = 1'b0; dec_valid = 1'b0; dec_bit = 1'b0;
    dec_sop = 1'b0; rx_hard = 2'b00; rx_eras = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(int'(numerr), 0, "R1 reset");

    exp_cnt = 0;
    for (int c = -DLY; c < N + 3; c++) begin
      @(negedge clk);
      if (c > 0) check(int'(numerr), exp_cnt, tag_of((c - 1 < N) ? c - 1 : N - 1));
      if (c >= 0 && c < N) begin
        dec_valid = e_dv[c]; dec_bit = e_bit[c];
        dec_sop = e_sop[c]; clr = e_clr[c];
      end else begin
        dec_valid = 1'b0; dec_bit = 1'b0; dec_sop = 1'b0; clr = 1'b0;
      end
      if (c + DLY >= 0 && c + DLY < N) begin
        rx_hard = e_hard[c + DLY]; rx_eras = e_eras[c + DLY];
      end else begin
        rx_hard = 2'b00; rx_eras = 2'b00;
      end
      // Expected count after the coming edge
      if (c >= 0) begin
        if (c < N && e_clr[c]) begin
          exp_cnt = 0;
        end else if (c >= 1 && c - 1 < N && e_dv[c - 1]) begin
          exp_cnt = e_sop[c - 1] ? sat(e_mm[c - 1]) : sat(exp_cnt + e_mm[c - 1]);
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule